// File: doc/BRIEF.md
# Coprocessor Control and Mailbox Register

This block is one 8-bit control/status register on a host microcontroller's register bus. The host uses it to manage an attached signal-processing coprocessor. The register does four jobs. It picks the host system clock rate by dividing the oscillator, and turns that rate into a divided clock-enable pulse. It sends a reset pulse to the coprocessor. It gates the coprocessor clock to halt it or let it run. It also carries an interrupt handshake in both directions between the two processors.

The register port has no flow control. A write takes effect at the oscillator clock edge where `reg_wr` is high and `reg_addr` matches the register address. A read is combinational: `reg_rdata` shows the register while the address matches, and 0 for any other address. No data streams through the block, so no valid/ready interface is needed. All pins are plain control and status lines that are sampled or driven every oscillator cycle.

The coprocessor raises the host interrupt through a set pulse input. It clears the interrupt it was given through an acknowledge input. Neither processor core nor the host interrupt controller is part of the block.

Top module: `cpctl_top`

## Requirements
- R1: After reset the register reads 0x10: clock select 00, run 1, all flags 0. `cop_clk_en` is 1, and `cop_rst`, `cop_irq2` and `host_irq3` are 0.
- R2: Bits 7:6 select the host clock divide ratio. 00 divides by DIV_SLOW (8), 01 by DIV_MID (4), and 10 or 11 by DIV_FAST (2). `host_clk_en` pulses for one oscillator cycle once per ratio. Bits 7:6 read back as written.
- R3: A new ratio takes effect only at a divided-clock boundary. The interval running at the write ends with the old ratio, so no interval is ever shorter than a full period.
- R4: Writing 1 to bit 5 raises `cop_rst` for exactly the one cycle after the write. Writing 0 to bit 5 raises no pulse.
- R5: Bit 5 reads 1 while the coprocessor is halted (run bit 0) and 0 while it runs.
- R6: Bit 4 is the run bit. `cop_clk_en` follows it from the cycle after the write, and it reads back as written.
- R7: Bits 3:2 always read 0. Writing to them has no effect.
- R8: Writing 1 to bit 1 sets `cop_irq2`, and writing 0 leaves it unchanged. Bit 1 reads the current level of `cop_irq2`.
- R9: `cop_irq2_ack` clears `cop_irq2` on the next cycle. If a host set arrives in the same cycle, the set wins.
- R10: A `cop_irq3_set` pulse sets `host_irq3`, and bit 0 reads it. A host write of 1 to bit 0 clears the flag, and a write of 0 has no effect.
- R11: When `cop_irq3_set` and a host clear of bit 0 come in the same cycle, the flag ends up set.
- R12: A write to any other address changes nothing. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| host_clk_en | output | 1 | Divided host clock-enable pulse |
| cop_rst | output | 1 | One-cycle coprocessor reset pulse |
| cop_clk_en | output | 1 | Coprocessor clock enable (run) |
| cop_irq2 | output | 1 | Interrupt line to the coprocessor |
| cop_irq2_ack | input | 1 | Coprocessor acknowledge of `cop_irq2` |
| cop_irq3_set | input | 1 | Coprocessor request to raise the host interrupt |
| host_irq3 | output | 1 | Interrupt flag to the host |

## Verification
The bench builds the block with its default parameters: 8-bit address, register at 0x0C, and divide ratios 8, 4 and 2. Divided periods of at most eight cycles let thousands of random cycles cross many ratio switches. Those switches land at every phase of the divider, including the edge where a boundary and a write coincide. Random writes, acknowledges and set pulses often land in the same cycle. This reaches the set-beats-clear and set-beats-acknowledge cases, alongside directed runs for each of them.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;

  // Clock select field encoding
  typedef enum logic [1:0] {
    CK_SLOW = 2'b00,
    CK_MID  = 2'b01,
    CK_FAST = 2'b10,
    CK_FST2 = 2'b11
  } clk_sel_e;

  // Bit positions within the register
  localparam int SEL_HI  = 7;
  localparam int SEL_LO  = 6;
  localparam int RST_BIT = 5;
  localparam int RUN_BIT = 4;
  localparam int RSV_HI  = 3;
  localparam int RSV_LO  = 2;
  localparam int I2_BIT  = 1;
  localparam int I3_BIT  = 0;

endpackage

// File: rtl/cpctl_clkdiv.sv
module cpctl_clkdiv
  import cpctl_pkg::*;
#(
  parameter int DIV_SLOW = 8,
  parameter int DIV_MID  = 4,
  parameter int DIV_FAST = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_req,
  output logic       tick
);
  localparam int CNT_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(DIV_SLOW - 1);
  localparam logic [CNT_W-1:0] LIM_MID  = CNT_W'(DIV_MID - 1);
  localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(DIV_FAST - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  clk_sel_e         act_sel;

  always_comb begin
    case (act_sel)
      CK_SLOW: lim = LIM_SLOW;
      CK_MID:  lim = LIM_MID;
      default: lim = LIM_FAST;
    endcase
  end

  assign tick = (cnt == lim);

  // The ratio in use is reloaded only when a period completes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_sel <= CK_SLOW;
    end else if (tick) begin
      cnt     <= '0;
      act_sel <= clk_sel_e'(sel_req);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(act_sel));

endmodule

// File: rtl/cpctl_irq.sv
module cpctl_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic i2_set,
  input  logic i2_ack,
  input  logic i3_set,
  input  logic i3_clr,
  output logic i2_flag,
  output logic i3_flag
);

  // Coprocessor-bound flag: a host set outranks the acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      i2_flag <= 1'b0;
    else if (i2_set) i2_flag <= 1'b1;
    else if (i2_ack) i2_flag <= 1'b0;
  end

  // Host-bound flag: a coprocessor set outranks the host clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      i3_flag <= 1'b0;
    else if (i3_set) i3_flag <= 1'b1;
    else if (i3_clr) i3_flag <= 1'b0;
  end

  // R8
  i2_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i2_flag) |-> $past(i2_set));

  // R9
  i2_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i2_ack && !i2_set) |=> !i2_flag);

  // R10
  i3_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i3_flag) |-> $past(i3_set));

  // R11
  i3_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i3_set |=> i3_flag);

endmodule

// File: rtl/cpctl_ctl.sv
module cpctl_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] sel_in,
  input  logic       rst_req,
  input  logic       run_in,
  output logic [1:0] sel_q,
  output logic       run_q,
  output logic       rst_pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      run_q <= 1'b1;
    end else if (wr_hit) begin
      sel_q <= sel_in;
      run_q <= run_in;
    end
  end

  // One pulse per write that carries a 1 in the reset field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pulse <= 1'b0;
    else        rst_pulse <= wr_hit && rst_req;
  end

  // R6
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(run_q) && $stable(sel_q));

  // R4
  no_stray_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> !rst_pulse);

endmodule

// File: rtl/cpctl_top.sv
module cpctl_top
  import cpctl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0C,
  parameter int              DIV_SLOW = 8,
  parameter int              DIV_MID  = 4,
  parameter int              DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              host_clk_en,
  output logic              cop_rst,
  output logic              cop_clk_en,
  output logic              cop_irq2,
  input  logic              cop_irq2_ack,
  input  logic              cop_irq3_set,
  output logic              host_irq3
);

  logic       addr_hit;
  logic       wr_hit;
  logic [1:0] sel_q;
  logic       run_q;
  logic [7:0] rd_word;

  assign addr_hit = (reg_addr == REG_ADDR);
  assign wr_hit   = reg_wr && addr_hit;

  cpctl_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .sel_in    (reg_wdata[SEL_HI:SEL_LO]),
    .rst_req   (reg_wdata[RST_BIT]),
    .run_in    (reg_wdata[RUN_BIT]),
    .sel_q     (sel_q),
    .run_q     (run_q),
    .rst_pulse (cop_rst)
  );

  cpctl_clkdiv #(
    .DIV_SLOW (DIV_SLOW),
    .DIV_MID  (DIV_MID),
    .DIV_FAST (DIV_FAST)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_req (sel_q),
    .tick    (host_clk_en)
  );

  cpctl_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .i2_set  (wr_hit && reg_wdata[I2_BIT]),
    .i2_ack  (cop_irq2_ack),
    .i3_set  (cop_irq3_set),
    .i3_clr  (wr_hit && reg_wdata[I3_BIT]),
    .i2_flag (cop_irq2),
    .i3_flag (host_irq3)
  );

  assign cop_clk_en = run_q;

  always_comb begin
    rd_word                 = '0;
    rd_word[SEL_HI:SEL_LO]  = sel_q;
    rd_word[RST_BIT]        = !run_q;
    rd_word[RUN_BIT]        = run_q;
    rd_word[I2_BIT]         = cop_irq2;
    rd_word[I3_BIT]         = host_irq3;
  end

  assign reg_rdata = addr_hit ? rd_word : 8'h00;

  // R7
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (reg_wdata[RSV_HI:RSV_LO] != 2'b00)) |=> (rd_word[RSV_HI:RSV_LO] == 2'b00));

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_clk_en |=> !host_clk_en);

  // R5
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cop_clk_en) |-> rd_word[RST_BIT]);

endmodule

// File: tb/tb_cpctl_top.sv
module tb_cpctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       host_clk_en, cop_rst, cop_clk_en, cop_irq2, host_irq3;
  logic       cop_irq2_ack = 1'b0;
  logic       cop_irq3_set = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected state
  logic [1:0] m_sel, m_act;
  logic       m_run, m_i2, m_i3, m_rst;
  int         m_cnt;

  always #4 clk = ~clk;

  cpctl_top dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_clk_en(host_clk_en),
    .cop_rst(cop_rst), .cop_clk_en(cop_clk_en), .cop_irq2(cop_irq2),
    .cop_irq2_ack(cop_irq2_ack), .cop_irq3_set(cop_irq3_set), .host_irq3(host_irq3)
  );

  function automatic int ratio_of(input logic [1:0] s);
    if (s == 2'b00) return 8;
    if (s == 2'b01) return 4;
    return 2;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R3 host_clk_en", {7'd0, host_clk_en}, {7'd0, (m_cnt == ratio_of(m_act) - 1)});
    chk("R4 cop_rst", {7'd0, cop_rst}, {7'd0, m_rst});
    chk("R6 cop_clk_en", {7'd0, cop_clk_en}, {7'd0, m_run});
    chk("R9 cop_irq2", {7'd0, cop_irq2}, {7'd0, m_i2});
    chk("R11 host_irq3", {7'd0, host_irq3}, {7'd0, m_i3});
    if (reg_addr == 8'h0C) begin
      chk("R2 rd sel", {6'd0, reg_rdata[7:6]}, {6'd0, m_sel});
      chk("R5 rd halted", {7'd0, reg_rdata[5]}, {7'd0, !m_run});
      chk("R6 rd run", {7'd0, reg_rdata[4]}, {7'd0, m_run});
      chk("R7 rd reserved", {6'd0, reg_rdata[3:2]}, 8'd0);
      chk("R8 rd irq2", {7'd0, reg_rdata[1]}, {7'd0, m_i2});
      chk("R10 rd irq3", {7'd0, reg_rdata[0]}, {7'd0, m_i3});
    end else begin
      chk("R12 rd other addr", reg_rdata, 8'h00);
    end
  endtask

  // Drive one cycle of inputs at a negedge, advance the model, check at the next negedge
  task automatic step(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                      input logic ack, input logic set);
    logic hit;
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    cop_irq2_ack = ack; cop_irq3_set = set;
    hit = wr && (addr == 8'h0C);
    if (m_cnt == ratio_of(m_act) - 1) begin
      m_cnt = 0;
      m_act = m_sel;
    end else begin
      m_cnt++;
    end
    m_rst = hit && wd[5];
    if (hit) begin
      m_sel = wd[7:6];
      m_run = wd[4];
    end
    if (hit && wd[1]) m_i2 = 1'b1;
    else if (ack)     m_i2 = 1'b0;
    if (set)              m_i3 = 1'b1;
    else if (hit && wd[0]) m_i3 = 1'b0;
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [7:0] keep(input logic [7:0] extra);
    return {m_sel, 1'b0, m_run, 4'b0000} | extra;
  endfunction

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int last_tick, first_after, iv;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    m_sel = 2'b00; m_act = 2'b00; m_run = 1'b1;
    m_i2 = 1'b0; m_i3 = 1'b0; m_rst = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_addr = 8'h0C;
    @(negedge clk);
    // R1 reset state (one edge already counted by the divider)
    m_cnt = 1;
    chk("R1 reset rdata", reg_rdata, 8'h10);
    chk("R1 reset outs", {4'd0, cop_rst, cop_clk_en, cop_irq2, host_irq3}, 8'b0000_0100);
    check_all();

    // R4 reset pulse then quiet; write 0 to bit 5 makes none
    step(1'b1, 8'h0C, keep(8'h20), 1'b0, 1'b0);
    step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0);
    chk("R4 pulse single", {7'd0, cop_rst}, 8'd0);
    step(1'b1, 8'h0C, keep(8'h00), 1'b0, 1'b0);
    step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0);
    // R5 R6 halt and resume
    step(1'b1, 8'h0C, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0);
    chk("R5 halted reads 1", {7'd0, reg_rdata[5]}, 8'd1);
    step(1'b1, 8'h0C, 8'h10, 1'b0, 1'b0);
    // R7 reserved write
    step(1'b1, 8'h0C, keep(8'h0C), 1'b0, 1'b0);
    // R8 R9 irq2 set, then ack and set together, then ack alone
    step(1'b1, 8'h0C, keep(8'h02), 1'b0, 1'b0);
    step(1'b1, 8'h0C, keep(8'h02), 1'b1, 1'b0);
    chk("R9 set beats ack", {7'd0, cop_irq2}, 8'd1);
    step(1'b0, 8'h0C, 8'h00, 1'b1, 1'b0);
    chk("R9 ack clears", {7'd0, cop_irq2}, 8'd0);
    // R10 R11 irq3 set, simultaneous clear, then clear
    step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b1);
    step(1'b1, 8'h0C, keep(8'h01), 1'b0, 1'b1);
    chk("R11 set beats clear", {7'd0, host_irq3}, 8'd1);
    step(1'b1, 8'h0C, keep(8'h00), 1'b0, 1'b0);
    chk("R10 write0 no effect", {7'd0, host_irq3}, 8'd1);
    step(1'b1, 8'h0C, keep(8'h01), 1'b0, 1'b0);
    chk("R10 write1 clears", {7'd0, host_irq3}, 8'd0);
    // R12 write to other address
    step(1'b1, 8'h0D, 8'hFF, 1'b0, 1'b0);
    chk("R12 other write ignored", {7'd0, cop_irq2}, 8'd0);

    // R2 R3 directed ratio switch: measure intervals at the ports
    for (int s = 0; s < 4; s++) begin
      logic [1:0] prev;
      prev = m_sel;
      while (!host_clk_en) step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0);
      step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0);
      step(1'b1, 8'h0C, {s[1:0], 6'b010000}, 1'b0, 1'b0);
      iv = 2;
      while (!host_clk_en) begin step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0); iv++; end
      chk("R3 old ratio finishes", iv[7:0], ratio_of(prev));
      iv = 0;
      do begin step(1'b0, 8'h0C, 8'h00, 1'b0, 1'b0); iv++; end while (!host_clk_en);
      chk("R2 new ratio", iv[7:0], ratio_of(s[1:0]));
    end

    // Constrained random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr, ack, set;
      logic [7:0] addr, wd;
      wr   = ($urandom % 10) < 3;
      addr = (($urandom % 10) < 8) ? 8'h0C : 8'($urandom);
      wd   = 8'($urandom);
      ack  = ($urandom % 10) < 2;
      set  = ($urandom % 10) < 1;
      step(wr, addr, wd, ack, set);
    end
    last_tick = 0; first_after = 0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule